// File: doc/BRIEF.md
# Conversion Result Readout Port

This block keeps the last conversion word in a holding register that is separate from the successive-approximation logic, so the host can fetch the previous result while the next conversion runs. The sequencer hands over a 16-bit word with a one-cycle load pulse. The host reads the word one byte at a time through an 8-bit port. A byte-lane select picks which half is driven, and the access is gated by active-low chip-select and read strobes.

A ready flag tells the host that an unread word is waiting. The flag is cleared only by fetching the upper byte. A fresh load always replaces the held word, even when the old one was never read. The sequencer delivers offset binary. A code-select input can turn this into two's complement on the way out by inverting the most significant bit. The port is modelled as a byte output plus a separate output-enable, which stands in for a three-state driver.

Top module: `conv_readout`

## Requirements
- R1: After reset the ready flag is 0 and the held word is 0000h, so with code-select high both bytes read 00h.
- R2: A cycle with `load_i` high captures `result_i` into the held word at that clock edge, and `ready_o` is 1 from the next cycle.
- R3: A load while `ready_o` is already 1 overwrites the unread word, and `ready_o` stays 1.
- R4: A read with `cs_n_i`=0, `rd_n_i`=0 and `byte_sel_i`=0 drives held bits 15..8 on `data_o` in the same cycle, and clears `ready_o` at the next edge.
- R5: A read with `byte_sel_i`=1 drives held bits 7..0, and `ready_o` keeps its value. With no load and no upper-byte read, `ready_o` never changes.
- R6: Reading either byte leaves the held word unchanged, so repeated reads return the same bytes.
- R7: `data_oe_o` is 1 only while `cs_n_i` and `rd_n_i` are both 0. Otherwise `data_oe_o` is 0, `data_o` is 00h, and a strobe with `cs_n_i`=1 does not clear `ready_o`.
- R8: With `code_sel_i`=0 (two's complement), bit 7 of the upper byte is the inverse of held bit 15, and the lower byte is unaffected. With `code_sel_i`=1 (offset binary), the bits pass unchanged. For example, 8000h reads as upper byte 00h or 80h respectively.
- R9: A read in the same cycle as a load returns the previously held word.
- R10: When a load and an upper-byte read occur in the same cycle, `ready_o` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | One-cycle pulse from the sequencer: capture `result_i` |
| result_i | input | 16 | Finished conversion word, offset binary |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| byte_sel_i | input | 1 | 0 selects bits 15..8, 1 selects bits 7..0 |
| code_sel_i | input | 1 | 0 selects two's complement, 1 selects offset binary |
| data_o | output | 8 | Selected byte; 00h while not driven |
| data_oe_o | output | 1 | High while the byte port is driven |
| ready_o | output | 1 | Unread word available |

## Verification
A sweep loads 256 words whose upper and lower bytes differ. For each word it reads the lower byte, then the upper byte, then the lower byte again, with the code select toggling between words. This shows byte-lane swaps, a missing or misplaced MSB inversion, flag clearing on the wrong lane, and reads that disturb the stored word. Directed patterns then cover back-to-back loads without a read, strobes without chip select, mid-scale 8000h in both codes, and a load that coincides with an upper-byte read. The last case shows whether the old word is served and whether the load wins over the flag clear.

// File: rtl/conv_readout_pkg.sv
package conv_readout_pkg;

    typedef enum logic {
        LANE_HI = 1'b0,
        LANE_LO = 1'b1
    } lane_e;

    typedef enum logic {
        CODE_TWOS   = 1'b0,
        CODE_OFFSET = 1'b1
    } code_e;

endpackage

// File: rtl/rdo_access_dec.sv
module rdo_access_dec
    import conv_readout_pkg::*;
(
    input  logic  cs_n,
    input  logic  rd_n,
    input  lane_e lane,
    output logic  drive_en,
    output logic  clear_req
);

    always_comb begin
        drive_en  = ~cs_n & ~rd_n;
        clear_req = drive_en & (lane == LANE_HI);
    end

endmodule

// File: rtl/rdo_word_store.sv
module rdo_word_store #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] result,
    input  logic              clear_req,
    output logic [WORD_W-1:0] word,
    output logic              ready
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              ready;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_req) begin
            st_d.ready = 1'b0;
        end
        if (load) begin
            st_d.word  = result;
            st_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word  = st_q.word;
    assign ready = st_q.ready;

endmodule

// File: rtl/rdo_byte_mux.sv
module rdo_byte_mux
    import conv_readout_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [WORD_W-1:0] word,
    input  lane_e             lane,
    input  code_e             code,
    input  logic              drive_en,
    output logic [BYTE_W-1:0] data,
    output logic              oe
);

    localparam int MSB_POS = BYTE_W - 1;

    logic [BYTE_W-1:0] hi_byte;
    logic [BYTE_W-1:0] lo_byte;
    logic              flip_msb;

    assign flip_msb = (code == CODE_TWOS);

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        if (i == MSB_POS) begin : g_sign
            assign hi_byte[i] = word[BYTE_W + i] ^ flip_msb;
        end else begin : g_plain
            assign hi_byte[i] = word[BYTE_W + i];
        end
        assign lo_byte[i] = word[i];
    end

    always_comb begin
        oe   = drive_en;
        data = '0;
        if (drive_en) begin
            data = (lane == LANE_HI) ? hi_byte : lo_byte;
        end
    end

endmodule

// File: rtl/conv_readout.sv
module conv_readout
    import conv_readout_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int BYTE_W = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] result_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              byte_sel_i,
    input  logic              code_sel_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              ready_o
);

    lane_e             lane;
    code_e             code;
    logic              drive_en;
    logic              clear_req;
    logic [WORD_W-1:0] held_word;

    assign lane = lane_e'(byte_sel_i);
    assign code = code_e'(code_sel_i);

    rdo_access_dec u_dec (
        .cs_n      (cs_n_i),
        .rd_n      (rd_n_i),
        .lane      (lane),
        .drive_en  (drive_en),
        .clear_req (clear_req)
    );

    rdo_word_store #(.WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_i),
        .result    (result_i),
        .clear_req (clear_req),
        .word      (held_word),
        .ready     (ready_o)
    );

    rdo_byte_mux #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_mux (
        .word     (held_word),
        .lane     (lane),
        .code     (code),
        .drive_en (drive_en),
        .data     (data_o),
        .oe       (data_oe_o)
    );

endmodule

// File: rtl/conv_readout_chk.sv
module conv_readout_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              cs_n_i,
    input logic              rd_n_i,
    input logic              byte_sel_i,
    input logic [BYTE_W-1:0] data_o,
    input logic              data_oe_o,
    input logic              ready_o
);

    logic hi_rd;
    assign hi_rd = !cs_n_i && !rd_n_i && !byte_sel_i;

    p_load_sets_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ready_o);

    p_hi_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_rd && !load_i) |=> !ready_o);

    p_flag_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_rd && !load_i) |=> $stable(ready_o));

    p_port_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i || rd_n_i) |-> (!data_oe_o && data_o == '0));

    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_rd && load_i) |=> ready_o);

endmodule

bind conv_readout conv_readout_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .cs_n_i     (cs_n_i),
    .rd_n_i     (rd_n_i),
    .byte_sel_i (byte_sel_i),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o),
    .ready_o    (ready_o)
);

// File: tb/sim_conv_readout.sv
module sim_conv_readout;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] result_i = '0;
    logic        cs_n_i = 1'b1;
    logic        rd_n_i = 1'b1;
    logic        byte_sel_i = 1'b1;
    logic        code_sel_i = 1'b1;
    logic [7:0]  data_o;
    logic        data_oe_o;
    logic        ready_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    conv_readout u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .result_i   (result_i),
        .cs_n_i     (cs_n_i),
        .rd_n_i     (rd_n_i),
        .byte_sel_i (byte_sel_i),
        .code_sel_i (code_sel_i),
        .data_o     (data_o),
        .data_oe_o  (data_oe_o),
        .ready_o    (ready_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called just after a falling edge
    task automatic do_load(input logic [15:0] v);
        load_i = 1'b1; result_i = v;
        @(posedge clk); @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic read_byte(input logic sel, input logic code,
                             output logic [7:0] d, output logic oe);
        cs_n_i = 1'b0; rd_n_i = 1'b0; byte_sel_i = sel; code_sel_i = code;
        #1;
        d = data_o; oe = data_oe_o;
        @(posedge clk); @(negedge clk);
        cs_n_i = 1'b1; rd_n_i = 1'b1;
        #1;
    endtask

    function automatic logic [7:0] exp_hi(input logic [15:0] v, input logic code);
        return v[15:8] ^ (code ? 8'h00 : 8'h80);
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       oe;
        logic [15:0] a;
        logic [15:0] b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        check("R1 ready", ready_o, 0);
        read_byte(1'b0, 1'b1, d, oe);
        check("R1 hi", d, 8'h00);
        read_byte(1'b1, 1'b1, d, oe);
        check("R1 lo", d, 8'h00);

        // R7 port quiet unless both strobes low
        cs_n_i = 1'b0; rd_n_i = 1'b1; #1;
        check("R7 oe cs only", data_oe_o, 0);
        check("R7 data cs only", data_o, 0);
        cs_n_i = 1'b1; rd_n_i = 1'b0; #1;
        check("R7 oe rd only", data_oe_o, 0);
        rd_n_i = 1'b1;
        @(negedge clk);

        // sweep: R2 R4 R5 R6 R8
        for (int k = 0; k < 256; k++) begin
            logic [15:0] v;
            logic        c;
            v = {k[7:0], ~k[7:0] ^ 8'h5a};
            c = k[0];
            do_load(v); #1;
            check("R2 ready after load", ready_o, 1);
            read_byte(1'b1, c, d, oe);
            check("R5 lo data", d, v[7:0]);
            check("R7 oe during read", oe, 1);
            check("R5 ready kept", ready_o, 1);
            read_byte(1'b0, c, d, oe);
            check("R8 hi data", d, exp_hi(v, c));
            check("R4 ready cleared", ready_o, 0);
            read_byte(1'b1, ~c, d, oe);
            check("R6 lo unchanged", d, v[7:0]);
            read_byte(1'b0, ~c, d, oe);
            check("R6 hi unchanged", d, exp_hi(v, ~c));
        end

        // R3 overwrite of unread word
        do_load(16'h1234);
        do_load(16'hA5C3); #1;
        check("R3 ready", ready_o, 1);
        read_byte(1'b1, 1'b1, d, oe);
        check("R3 lo", d, 8'hC3);
        read_byte(1'b0, 1'b1, d, oe);
        check("R3 hi", d, 8'hA5);

        // R7 strobe without chip select does not clear
        do_load(16'h0F0F);
        cs_n_i = 1'b1; rd_n_i = 1'b0; byte_sel_i = 1'b0;
        @(posedge clk); @(negedge clk);
        rd_n_i = 1'b1; #1;
        check("R7 no clear without cs", ready_o, 1);

        // R8 mid-scale
        do_load(16'h8000);
        read_byte(1'b0, 1'b0, d, oe);
        check("R8 mid twos", d, 8'h00);
        read_byte(1'b0, 1'b1, d, oe);
        check("R8 mid offset", d, 8'h80);
        read_byte(1'b1, 1'b0, d, oe);
        check("R8 lo unaffected", d, 8'h00);
        check("R4 ready after hi", ready_o, 0);

        // R9 and R10: load coinciding with upper-byte read
        a = 16'h3C77;
        b = 16'hC311;
        do_load(a);
        read_byte(1'b0, 1'b1, d, oe);
        check("R4 pre clear", ready_o, 0);
        load_i = 1'b1; result_i = b;
        cs_n_i = 1'b0; rd_n_i = 1'b0; byte_sel_i = 1'b0; code_sel_i = 1'b1;
        #1;
        check("R9 old word served", data_o, a[15:8]);
        @(posedge clk); @(negedge clk);
        load_i = 1'b0; cs_n_i = 1'b1; rd_n_i = 1'b1; #1;
        check("R10 load wins", ready_o, 1);
        read_byte(1'b0, 1'b1, d, oe);
        check("R9 new word after", d, b[15:8]);

        // R1 reset clears word and flag mid-run
        do_load(16'hFFFF);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; #1;
        check("R1 ready after reset", ready_o, 0);
        read_byte(1'b0, 1'b1, d, oe);
        check("R1 word cleared", d, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule